// File: doc/BRIEF.md
# LAPD Frame Address Filter

This block screens the two-byte address field of each received D-channel frame and decides whether the frame is for this terminal. Address bytes arrive one per beat on a valid/ready stream. A start marker travels with the first byte of a frame and an end marker travels with its last byte. The first byte is tested against a set of programmable service-point candidates. The second byte is tested against a set of programmable endpoint candidates under a per-bit mask, and also against the fixed broadcast endpoint value. The block gives one decision pulse per frame, with flags that show which candidates matched.

The block never applies back-pressure. A beat is taken on every cycle in which valid is high. Bytes after the second byte of a frame, and bytes that arrive while no frame is open, are consumed and have no effect. A small register port writes and reads the candidates, the mask and one control bit. The read path is combinational.

Top module: `lapd_addr_filter`

## Requirements
- R1: After reset, all six registers read 00h: service candidates 1 and 2 at addresses 0 and 1, endpoint candidates 1 and 2 at addresses 2 and 3, the endpoint mask at address 4, and the control register at address 5.
- R2: A write to addresses 0 to 5 is read back unchanged. Only bit 0 of the control register is stored. Addresses 6 and 7 read 00h, and writes to them change no register.
- R3: A first byte that equals service candidate i sets bit i of `dec_sapi_hit`.
- R4: When control bit 0 is 0 (the reset value), bit 1 of the first byte (the command/response bit) takes part in the service comparison. When control bit 0 is 1, that bit is left out of the comparison.
- R5: Bit i of `dec_tei_hit` (i = 0, 1) is set when the second byte equals endpoint candidate i+1 in every bit position where the mask holds 0. A mask bit of 1 leaves that position out of the comparison.
- R6: Bit 2 of `dec_tei_hit` is set when the second byte is FFh (broadcast endpoint 127 with the extension bit set). The mask has no effect on this comparison.
- R7: `dec_valid` is high for exactly one cycle, in the cycle after the second byte's beat. `dec_accept` is 1 only when `dec_sapi_hit` and `dec_tei_hit` each have at least one bit set.
- R8: A frame whose start beat also carries the end marker gives a decision pulse with `dec_short`=1, `dec_accept`=0 and all hit flags 0.
- R9: A start beat restarts the frame and discards earlier match state. Third and later bytes, and bytes with no frame open, cause no pulse.
- R10: `in_ready` is always 1. While `dec_valid` is 0, `dec_accept`, `dec_short` and all hit flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Address byte valid |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first byte of a frame |
| in_eof | input | 1 | Byte is the last byte of a frame |
| cfg_wen | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_short | output | 1 | Frame ended before its second byte |
| dec_sapi_hit | output | 2 | Matching service candidates |
| dec_tei_hit | output | 3 | Endpoint match flags: candidate 1, candidate 2, broadcast |

## Verification
Directed frames try the comparators one at a time:
- A first byte that differs from a candidate only in the command/response bit separates the two settings of the control bit.
- A second byte that differs from a candidate only in masked positions shows that the mask is applied.
- FFh with the mask cleared shows that the broadcast comparison does not depend on the mask.

Single-byte frames, a restart in the middle of a frame, and bytes sent outside any frame separate the sequencing cases from the address comparisons. Random frames mix the following and so test how the service and endpoint results combine into one decision:
- candidate values
- candidate values with bits flipped
- FFh
- free bytes
- random mask and control settings

// File: rtl/lapd_filt_pkg.sv
package lapd_filt_pkg;
  typedef enum logic [0:0] {
    FS_IDLE     = 1'b0,
    FS_WAIT_TEI = 1'b1
  } fs_state_e;

  localparam int unsigned CR_BIT_POS = 1;
endpackage

// File: rtl/lapd_cfg_regs.sv
module lapd_cfg_regs #(
  parameter int NSAPI = 2,
  parameter int NTEI  = 2,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wen,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [NSAPI-1:0][DW-1:0]   sapi_o,
  output logic [NTEI-1:0][DW-1:0]    tei_o,
  output logic [DW-1:0]              mask_o,
  output logic                       cr_skip_o
);
  localparam int TEI_BASE = NSAPI;
  localparam int MASK_IDX = NSAPI + NTEI;
  localparam int CTRL_IDX = MASK_IDX + 1;

  logic [NSAPI-1:0][DW-1:0] sapi_q;
  logic [NTEI-1:0][DW-1:0]  tei_q;
  logic [DW-1:0]            mask_q;
  logic                     cr_skip_q;

  for (genvar gs = 0; gs < NSAPI; gs++) begin : g_sapi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sapi_q[gs] <= '0;
      else if (wen && addr == AW'(gs))     sapi_q[gs] <= wdata;
    end
  end

  for (genvar gt = 0; gt < NTEI; gt++) begin : g_tei
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  tei_q[gt] <= '0;
      else if (wen && addr == AW'(TEI_BASE + gt))  tei_q[gt] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      cr_skip_q <= 1'b0;
    end else if (wen) begin
      if (addr == AW'(MASK_IDX)) mask_q    <= wdata;
      if (addr == AW'(CTRL_IDX)) cr_skip_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSAPI; i++)
      if (addr == AW'(i)) rdata = sapi_q[i];
    for (int j = 0; j < NTEI; j++)
      if (addr == AW'(TEI_BASE + j)) rdata = tei_q[j];
    if (addr == AW'(MASK_IDX)) rdata = mask_q;
    if (addr == AW'(CTRL_IDX)) rdata = {{(DW-1){1'b0}}, cr_skip_q};
  end

  assign sapi_o    = sapi_q;
  assign tei_o     = tei_q;
  assign mask_o    = mask_q;
  assign cr_skip_o = cr_skip_q;
endmodule

// File: rtl/lapd_addr_match.sv
module lapd_addr_match
  import lapd_filt_pkg::*;
#(
  parameter int NSAPI = 2,
  parameter int NTEI  = 2,
  parameter int DW    = 8
) (
  input  logic [DW-1:0]             byte_i,
  input  logic [NSAPI-1:0][DW-1:0]  sapi_i,
  input  logic [NTEI-1:0][DW-1:0]   tei_i,
  input  logic [DW-1:0]             mask_i,
  input  logic                      cr_skip_i,
  output logic [NSAPI-1:0]          sapi_hit_o,
  output logic [NTEI:0]             tei_hit_o
);
  localparam logic [DW-1:0] CR_SEL    = DW'(1) << CR_BIT_POS;
  localparam logic [DW-1:0] GROUP_VAL = {DW{1'b1}};

  logic [DW-1:0] sapi_care;
  logic [DW-1:0] tei_care;

  assign sapi_care = cr_skip_i ? ~CR_SEL : {DW{1'b1}};
  assign tei_care  = ~mask_i;

  for (genvar gs = 0; gs < NSAPI; gs++) begin : g_sapi_cmp
    assign sapi_hit_o[gs] = ((byte_i ^ sapi_i[gs]) & sapi_care) == '0;
  end

  for (genvar gt = 0; gt < NTEI; gt++) begin : g_tei_cmp
    assign tei_hit_o[gt] = ((byte_i ^ tei_i[gt]) & tei_care) == '0;
  end

  assign tei_hit_o[NTEI] = (byte_i == GROUP_VAL);
endmodule

// File: rtl/lapd_frame_seq.sv
module lapd_frame_seq
  import lapd_filt_pkg::*;
#(
  parameter int NSAPI = 2,
  parameter int NTEI  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [NSAPI-1:0] sapi_hit_i,
  input  logic [NTEI:0]    tei_hit_i,
  output logic             dec_valid_o,
  output logic             dec_accept_o,
  output logic             dec_short_o,
  output logic [NSAPI-1:0] dec_sapi_o,
  output logic [NTEI:0]    dec_tei_o
);
  fs_state_e        state_q;
  logic [NSAPI-1:0] sapi_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= FS_IDLE;
      sapi_seen_q  <= '0;
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
      dec_short_o  <= 1'b0;
      dec_sapi_o   <= '0;
      dec_tei_o    <= '0;
    end else begin
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
      dec_short_o  <= 1'b0;
      dec_sapi_o   <= '0;
      dec_tei_o    <= '0;
      if (beat_i) begin
        if (sof_i) begin
          sapi_seen_q <= sapi_hit_i;
          if (eof_i) begin
            dec_valid_o <= 1'b1;
            dec_short_o <= 1'b1;
            state_q     <= FS_IDLE;
          end else begin
            state_q     <= FS_WAIT_TEI;
          end
        end else if (state_q == FS_WAIT_TEI) begin
          dec_valid_o  <= 1'b1;
          dec_sapi_o   <= sapi_seen_q;
          dec_tei_o    <= tei_hit_i;
          dec_accept_o <= (|sapi_seen_q) && (|tei_hit_i);
          state_q      <= FS_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/lapd_addr_filter.sv
module lapd_addr_filter #(
  parameter int NSAPI  = 2,
  parameter int NTEI   = 2,
  parameter int DW     = 8,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              cfg_wen,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_short,
  output logic [NSAPI-1:0]  dec_sapi_hit,
  output logic [NTEI:0]     dec_tei_hit
);
  logic [NSAPI-1:0][DW-1:0] sapi_w;
  logic [NTEI-1:0][DW-1:0]  tei_w;
  logic [DW-1:0]            mask_w;
  logic                     cr_skip_w;
  logic [NSAPI-1:0]         sapi_hit_w;
  logic [NTEI:0]            tei_hit_w;
  logic                     beat_w;

  assign in_ready = 1'b1;
  assign beat_w   = in_valid & in_ready;

  lapd_cfg_regs #(.NSAPI(NSAPI), .NTEI(NTEI), .DW(DW), .AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(cfg_wen), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .sapi_o(sapi_w), .tei_o(tei_w),
    .mask_o(mask_w), .cr_skip_o(cr_skip_w)
  );

  lapd_addr_match #(.NSAPI(NSAPI), .NTEI(NTEI), .DW(DW)) u_match (
    .byte_i(in_data), .sapi_i(sapi_w), .tei_i(tei_w), .mask_i(mask_w),
    .cr_skip_i(cr_skip_w), .sapi_hit_o(sapi_hit_w), .tei_hit_o(tei_hit_w)
  );

  lapd_frame_seq #(.NSAPI(NSAPI), .NTEI(NTEI)) u_seq (
    .clk(clk), .rst_n(rst_n), .beat_i(beat_w), .sof_i(in_sof), .eof_i(in_eof),
    .sapi_hit_i(sapi_hit_w), .tei_hit_i(tei_hit_w),
    .dec_valid_o(dec_valid), .dec_accept_o(dec_accept), .dec_short_o(dec_short),
    .dec_sapi_o(dec_sapi_hit), .dec_tei_o(dec_tei_hit)
  );
endmodule

// File: rtl/lapd_addr_filter_chk.sv
module lapd_addr_filter_chk #(
  parameter int NSAPI = 2,
  parameter int NTEI  = 2,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DW-1:0]    in_data,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic             dec_short,
  input logic [NSAPI-1:0] dec_sapi_hit,
  input logic [NTEI:0]    dec_tei_hit
);
  assert_pulse_needs_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_ready));

  assert_accept_needs_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_accept) |-> ((|dec_sapi_hit) && (|dec_tei_hit)));

  assert_short_rejects_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_short |-> (dec_valid && !dec_accept && dec_sapi_hit == '0 && dec_tei_hit == '0));

  assert_group_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_short && $past(in_data) == {DW{1'b1}}) |-> dec_tei_hit[NTEI]);

  assert_quiet_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && !dec_short && dec_sapi_hit == '0 && dec_tei_hit == '0));
endmodule

bind lapd_addr_filter lapd_addr_filter_chk #(.NSAPI(NSAPI), .NTEI(NTEI), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .dec_valid(dec_valid), .dec_accept(dec_accept),
  .dec_short(dec_short), .dec_sapi_hit(dec_sapi_hit), .dec_tei_hit(dec_tei_hit)
);

// File: tb/sim_lapd_addr_filter.sv
`timescale 1ns/1ps
module sim_lapd_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       cfg_wen = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       dec_valid, dec_accept, dec_short;
  logic [1:0] dec_sapi_hit;
  logic [2:0] dec_tei_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] sapi_m [2];
  logic [7:0] tei_m [2];
  logic [7:0] mask_m;
  logic       crx_m;

  always #4 clk = ~clk;

  lapd_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .cfg_wen(cfg_wen),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_short(dec_short),
    .dec_sapi_hit(dec_sapi_hit), .dec_tei_hit(dec_tei_hit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sapi(input logic [7:0] b);
    logic [7:0] care = crx_m ? 8'hFD : 8'hFF;
    for (int i = 0; i < 2; i++) exp_sapi[i] = ((b ^ sapi_m[i]) & care) == 8'h00;
  endfunction

  function automatic logic [2:0] exp_tei(input logic [7:0] b);
    for (int i = 0; i < 2; i++) exp_tei[i] = ((b ^ tei_m[i]) & ~mask_m) == 8'h00;
    exp_tei[2] = (b == 8'hFF);
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wen = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wen = 1'b0;
    case (a)
      3'd0: sapi_m[0] = d;
      3'd1: sapi_m[1] = d;
      3'd2: tei_m[0] = d;
      3'd3: tei_m[1] = d;
      3'd4: mask_m = d;
      3'd5: crx_m = d[0];
      default: ;
    endcase
  endtask

  task automatic cfg_check(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic beat(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic expect_quiet(input string tag);
    @(negedge clk);
    check(tag, {dec_valid, dec_accept, dec_short, dec_sapi_hit, dec_tei_hit}, 32'h0);
  endtask

  task automatic expect_dec(input logic [7:0] b0, input logic [7:0] b1);
    logic [1:0] es = exp_sapi(b0);
    logic [2:0] et = exp_tei(b1);
    @(negedge clk);
    check("R7 valid", dec_valid, 1'b1);
    check("R7 accept", dec_accept, (|es) && (|et));
    check("R3/R4 sapi flags", dec_sapi_hit, es);
    check("R5/R6 tei flags", dec_tei_hit, et);
    check("R8 short low", dec_short, 1'b0);
    @(negedge clk);
    check("R7 one-cycle pulse", dec_valid, 1'b0);
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int extra);
    beat(b0, 1'b1, 1'b0);
    expect_quiet("R9 no pulse after first byte");
    beat(b1, 1'b0, extra == 0);
    expect_dec(b0, b1);
    for (int k = 0; k < extra; k++) begin
      beat(8'($urandom), 1'b0, k == extra - 1);
      expect_quiet("R9 trailing byte ignored");
    end
  endtask

  task automatic short_frame(input logic [7:0] b0);
    beat(b0, 1'b1, 1'b1);
    @(negedge clk);
    check("R8 short pulse", {dec_valid, dec_short, dec_accept, dec_sapi_hit, dec_tei_hit},
          {1'b1, 1'b1, 1'b0, 2'b00, 3'b000});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    sapi_m[0] = 0; sapi_m[1] = 0; tei_m[0] = 0; tei_m[1] = 0; mask_m = 0; crx_m = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values; R10 ready and quiet outputs
    for (int a = 0; a < 8; a++) cfg_check(3'(a), 8'h00, "R1 reset read");
    check("R10 ready high", in_ready, 1'b1);
    expect_quiet("R10 quiet after reset");

    // R7 reset registers: 00 00 matches every candidate
    frame(8'h00, 8'h00, 0);

    // R2 register map
    cfg_write(3'd0, 8'h0C); cfg_write(3'd1, 8'h40);
    cfg_write(3'd2, 8'h03); cfg_write(3'd3, 8'h85);
    cfg_write(3'd4, 8'hF0); cfg_write(3'd5, 8'hFF);
    cfg_write(3'd6, 8'h5A); cfg_write(3'd7, 8'hA5);
    cfg_check(3'd0, 8'h0C, "R2 read sapi1");
    cfg_check(3'd1, 8'h40, "R2 read sapi2");
    cfg_check(3'd2, 8'h03, "R2 read tei1");
    cfg_check(3'd3, 8'h85, "R2 read tei2");
    cfg_check(3'd4, 8'hF0, "R2 read mask");
    cfg_check(3'd5, 8'h01, "R2 read ctrl");
    cfg_check(3'd6, 8'h00, "R2 unused 6");
    cfg_check(3'd7, 8'h00, "R2 unused 7");

    // R4 command/response bit excluded then included
    frame(8'h0E, 8'h03, 1);
    cfg_write(3'd5, 8'h00);
    frame(8'h0E, 8'h03, 0);
    frame(8'h0C, 8'h03, 0);

    // R5 masked compare: 0x53 vs 0x03 differs only in masked bits
    frame(8'h40, 8'h53, 0);
    frame(8'h40, 8'h5B, 0);
    // R6 broadcast with mask cleared
    cfg_write(3'd4, 8'h00);
    frame(8'h40, 8'hFF, 2);
    frame(8'h41, 8'hFF, 0);

    // R8 short frame
    short_frame(8'h0C);
    expect_quiet("R8 pulse ends");

    // R9 bytes with no frame open
    beat(8'h0C, 1'b0, 1'b0);
    expect_quiet("R9 idle byte");
    beat(8'h03, 1'b0, 1'b1);
    expect_quiet("R9 idle byte with end");

    // R9 restart mid-frame: first start byte is a miss, second start byte hits
    beat(8'h77, 1'b1, 1'b0);
    expect_quiet("R9 first start");
    frame(8'h0C, 8'h03, 0);

    // Random frames
    for (int n = 0; n < 400; n++) begin
      logic [7:0] b0, b1;
      if (n % 25 == 0) begin
        cfg_write(3'd0, 8'($urandom)); cfg_write(3'd1, 8'($urandom));
        cfg_write(3'd2, 8'($urandom)); cfg_write(3'd3, 8'($urandom));
        cfg_write(3'd4, 8'($urandom) & 8'($urandom));
        cfg_write(3'd5, 8'($urandom));
      end
      case ($urandom % 4)
        0: b0 = sapi_m[0];
        1: b0 = sapi_m[1];
        2: b0 = sapi_m[$urandom % 2] ^ 8'h02;
        default: b0 = 8'($urandom);
      endcase
      case ($urandom % 4)
        0: b1 = tei_m[0] ^ (8'($urandom) & mask_m);
        1: b1 = tei_m[1];
        2: b1 = 8'hFF;
        default: b1 = 8'($urandom);
      endcase
      if ($urandom % 10 == 0) short_frame(b0);
      else frame(b0, b1, int'($urandom % 3));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule